// File: doc/BRIEF.md
# Battery-Backed RAM With Time-Of-Year Clock Window

This block serves a memory-mapped, non-volatile RAM region on a simple synchronous bus. Every register slot sits on a four-byte address stride, and the slot number is obtained by subtracting a base address and dropping the two low address bits. The lowest fourteen slots hold no RAM. Accesses to them are forwarded to an external time-of-year clock chip through a narrow register port. All higher slots are served from local storage, and a write there replaces a single byte lane of the stored word.

On the bus, data travels two bit positions above where it is stored. Write data is shifted down by two before use, and read data, from either source, is shifted up by two before it is returned. A battery-low flag comes up set after reset. A pulse on `img_valid` clears it, which tells the block that a backing image has been supplied. A pulse on `img_gone` sets it again. A small behavioural clock-chip register model, `nvw_tc_stub`, is part of the RTL so that tests have something on the other side of the clock-chip port.

Top module: `nvram_window`

## Requirements
- R1: The slot index is (bus_addr − BASE_ADDR) >> 2, and the byte lane is bus_addr[1:0] (BASE_ADDR is longword aligned). An address below BASE_ADDR, or with an index of NUM_SLOTS or more, is outside the window. Such an address reads as 0, and a write to it changes nothing.
- R2: Indices 0 to 13 go to the clock-chip port. tc_idx carries the index and tc_we is high in the same cycle as bus_we. These slots never touch local RAM.
- R3: bus_rdata is registered. In the cycle after an address is applied, it shows the selected source value shifted left by 2, truncated to 32 bits. A clock-chip source is zero-extended from 8 bits first.
- R4: Write data is shifted right by 2 before use. The byte written is bus_wdata[9:2], and bus_wdata[1:0] and bus_wdata[31:10] have no effect.
- R5: A RAM write places the byte at bit offset lane×8 of the addressed word and keeps the other 24 bits unchanged.
- R6: Synchronous active-high reset clears every RAM word to 0, sets batt_low to 1 and clears bus_rdata to 0.
- R7: A pulse on img_valid clears batt_low from the next cycle. A pulse on img_gone sets it from the next cycle. When both are high, img_gone wins.
- R8: A read of the slot being written in the same cycle returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data, bus-aligned (payload in bits 9:2) |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Registered read data, payload shifted up by 2 |
| img_valid | input | 1 | Backing image supplied (pulse) |
| img_gone | input | 1 | Backing image removed (pulse) |
| batt_low | output | 1 | Battery-low indicator |
| tc_idx | output | 4 | Clock-chip register index |
| tc_wdata | output | 8 | Clock-chip write data |
| tc_we | output | 1 | Clock-chip write strobe |
| tc_rdata | input | 8 | Clock-chip read data, combinational |

## Verification
The bench builds the block with AW = 16, BASE_ADDR = 0x0100 and NUM_SLOTS = 20. With only six RAM slots above the clock-chip range, the top edge of the window, slot 20, is a single address step past the last RAM word. That puts both out-of-window cases, above the window and below the base, within a few directed accesses. The small window also lets a reference copy of every RAM word be kept in the bench, so that lane merges, truncation of the upper bits on readback and read-during-write ordering can all be checked exactly.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    localparam int CLK_SLOTS = 14;
    localparam int TC_IW     = 4;
    localparam int BUS_W     = 32;
    localparam int BUS_SHIFT = 2;

    typedef struct packed {
        logic       in_win;
        logic       is_clk;
        logic [1:0] lane;
    } nvw_dec_t;

    function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] lane);
        return {{(BUS_W-8){1'b0}}, 8'hFF} << {lane, 3'b000};
    endfunction

    function automatic logic [BUS_W-1:0] to_bus(input logic [BUS_W-1:0] v);
        return v << BUS_SHIFT;
    endfunction
endpackage

// File: rtl/nvw_decode.sv
module nvw_decode #(
    parameter int AW = 16,
    parameter logic [AW-1:0] BASE_ADDR = '0,
    parameter int NUM_SLOTS = 64,
    parameter int IW = 6
) (
    input  logic [AW-1:0]     addr,
    output nvw_pkg::nvw_dec_t dec,
    output logic [IW-1:0]     idx
);
    logic [AW-1:0] off;
    logic [AW-1:0] slot;

    always_comb begin
        off        = addr - BASE_ADDR;
        slot       = off >> 2;
        dec.in_win = (addr >= BASE_ADDR) && (32'(slot) < NUM_SLOTS);
        dec.is_clk = dec.in_win && (32'(slot) < nvw_pkg::CLK_SLOTS);
        dec.lane   = off[1:0];
        idx        = IW'(slot);
    end
endmodule

// File: rtl/nvw_ram.sv
module nvw_ram #(
    parameter int IW = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IW-1:0]             idx,
    input  logic [1:0]                lane,
    input  logic                      we,
    input  logic [7:0]                wbyte,
    output logic [nvw_pkg::BUS_W-1:0] rd_word
);
    localparam int DEPTH = 1 << IW;
    localparam int W     = nvw_pkg::BUS_W;

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] mask;
    logic [W-1:0] ins;

    assign rd_word = mem[idx];
    assign mask    = nvw_pkg::lane_mask(lane);
    assign ins     = {{(W-8){1'b0}}, wbyte} << {lane, 3'b000};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= (mem[idx] & ~mask) | ins;
        end
    end

    // R5: bytes outside the written lane keep their old value
    a_r5_lane_keep: assert property (@(posedge clk) disable iff (rst)
        we |=> (((mem[$past(idx)] ^ $past(rd_word)) & ~$past(mask)) == '0));
endmodule

// File: rtl/nvw_batt.sv
module nvw_batt (
    input  logic clk,
    input  logic rst,
    input  logic img_valid,
    input  logic img_gone,
    output logic batt_low
);
    always_ff @(posedge clk) begin
        if (rst)            batt_low <= 1'b1;
        else if (img_gone)  batt_low <= 1'b1;
        else if (img_valid) batt_low <= 1'b0;
    end

    // R7: removal sets the indicator on the next cycle
    a_r7_gone_sets: assert property (@(posedge clk) disable iff (rst)
        img_gone |=> batt_low);
    // R7: a lone valid pulse clears it on the next cycle
    a_r7_valid_clears: assert property (@(posedge clk) disable iff (rst)
        (img_valid && !img_gone) |=> !batt_low);
endmodule

// File: rtl/nvw_tc_stub.sv
module nvw_tc_stub (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [nvw_pkg::TC_IW-1:0] idx,
    input  logic [7:0]                wdata,
    input  logic                      we,
    output logic [7:0]                rdata
);
    localparam int N = nvw_pkg::CLK_SLOTS;

    logic [7:0] regs [N];

    assign rdata = (32'(idx) < N) ? regs[idx] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= 8'h00;
        end else if (we && (32'(idx) < N)) begin
            regs[idx] <= wdata;
        end
    end
endmodule

// File: rtl/nvram_window.sv
module nvram_window #(
    parameter int AW = 16,
    parameter logic [AW-1:0] BASE_ADDR = 16'h0100,
    parameter int NUM_SLOTS = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [AW-1:0]             bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic                      bus_we,
    output logic [31:0]               bus_rdata,
    input  logic                      img_valid,
    input  logic                      img_gone,
    output logic                      batt_low,
    output logic [3:0]                tc_idx,
    output logic [7:0]                tc_wdata,
    output logic                      tc_we,
    input  logic [7:0]                tc_rdata
);
    import nvw_pkg::*;

    localparam int IW = $clog2(NUM_SLOTS);

    nvw_dec_t      dec;
    logic [IW-1:0] idx;
    logic [31:0]   ram_word;
    logic [31:0]   src;
    logic [7:0]    wbyte;
    logic          ram_we;
    logic          unused_wbits;

    nvw_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR), .NUM_SLOTS(NUM_SLOTS), .IW(IW)) u_dec (
        .addr(bus_addr), .dec(dec), .idx(idx)
    );

    assign wbyte        = 8'(bus_wdata >> BUS_SHIFT);
    assign unused_wbits = ^{bus_wdata[31:10], bus_wdata[1:0]};
    assign ram_we       = bus_we && dec.in_win && !dec.is_clk;

    nvw_ram #(.IW(IW)) u_ram (
        .clk(clk), .rst(rst), .idx(idx), .lane(dec.lane),
        .we(ram_we), .wbyte(wbyte), .rd_word(ram_word)
    );

    nvw_batt u_batt (
        .clk(clk), .rst(rst), .img_valid(img_valid),
        .img_gone(img_gone), .batt_low(batt_low)
    );

    assign tc_idx   = idx[TC_IW-1:0];
    assign tc_wdata = wbyte;
    assign tc_we    = bus_we && dec.is_clk;

    assign src = dec.is_clk ? {24'h0, tc_rdata} : ram_word;

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= dec.in_win ? to_bus(src) : '0;
    end

    // R2: the clock chip is only written on a bus write
    a_r2_tc_we_bus: assert property (@(posedge clk) disable iff (rst)
        tc_we |-> bus_we);
    // R2: clock-chip slots and RAM writes are exclusive
    a_r2_no_ram_clash: assert property (@(posedge clk) disable iff (rst)
        !(tc_we && ram_we));
    // R3: returned data always has its two low bits clear
    a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[1:0] == 2'b00);
    // R1: an out-of-window address reads back as zero
    a_r1_outside_zero: assert property (@(posedge clk) disable iff (rst)
        !dec.in_win |=> bus_rdata == '0);
endmodule

// File: tb/nvram_window_tb.sv
module nvram_window_tb;
    localparam int AW = 16;
    localparam logic [AW-1:0] BASE = 16'h0100;
    localparam int NS = 20;

    logic clk = 0;
    logic rst;
    logic [AW-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic bus_we, img_valid, img_gone, batt_low;
    logic [3:0] tc_idx;
    logic [7:0] tc_wdata, tc_rdata;
    logic tc_we;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NS];
    logic [7:0]  tmodel [14];

    always #10 clk = ~clk;

    nvram_window #(.AW(AW), .BASE_ADDR(BASE), .NUM_SLOTS(NS)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .img_valid(img_valid),
        .img_gone(img_gone), .batt_low(batt_low), .tc_idx(tc_idx),
        .tc_wdata(tc_wdata), .tc_we(tc_we), .tc_rdata(tc_rdata)
    );

    nvw_tc_stub u_tc (
        .clk(clk), .rst(rst), .idx(tc_idx), .wdata(tc_wdata),
        .we(tc_we), .rdata(tc_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] a_of(input int slot, input int lane);
        return BASE + AW'(slot * 4 + lane);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        @(negedge clk);
        check(req, bus_rdata, exp);
    endtask

    task automatic ram_wr(input int slot, input int lane, input logic [31:0] d);
        logic [7:0] b;
        b = d[9:2];
        wr(a_of(slot, lane), d);
        model[slot] = (model[slot] & ~(32'hFF << (lane * 8))) | ({24'h0, b} << (lane * 8));
    endtask

    task automatic t_reset;
        check("R6 rdata", bus_rdata, 32'h0);
        check("R6 batt_low", {31'h0, batt_low}, 32'h1);
        for (int s = 14; s < NS; s++) rd_check("R6 ram clear", a_of(s, 0), 32'h0);
    endtask

    task automatic t_merge;
        ram_wr(14, 0, 32'hAB << 2);
        rd_check("R5 lane0", a_of(14, 0), model[14] << 2);
        ram_wr(14, 2, 32'h5C << 2);
        rd_check("R5 lane2 keeps lane0", a_of(14, 0), model[14] << 2);
        check("R5 model value", model[14], 32'h005C00AB);
        ram_wr(15, 1, 32'h77 << 2);
        ram_wr(15, 3, 32'h12 << 2);
        rd_check("R5 lanes1+3", a_of(15, 2), 32'h12007700 << 2);
    endtask

    task automatic t_shift;
        ram_wr(16, 0, 32'hFFFF_FC00 | (32'h3C << 2) | 32'h3);
        rd_check("R4 ignored bits", a_of(16, 0), 32'h3C << 2);
        ram_wr(17, 3, 32'hFF << 2);
        rd_check("R3 truncation", a_of(17, 0), 32'hFC000000);
    endtask

    task automatic t_clock;
        wr(a_of(3, 0), (32'h5A << 2) | 32'h2);
        tmodel[3] = 8'h5A;
        rd_check("R2 clock slot read", a_of(3, 0), 32'h5A << 2);
        wr(a_of(13, 1), 32'hC3 << 2);
        rd_check("R2 clock slot 13", a_of(13, 0), 32'hC3 << 2);
        rd_check("R2 clock slot 0 untouched", a_of(0, 0), 32'h0);
        rd_check("R2 ram slot 14 unaffected", a_of(14, 0), model[14] << 2);
    endtask

    task automatic t_window;
        wr(a_of(NS, 0), 32'hEE << 2);
        rd_check("R1 above window", a_of(NS, 0), 32'h0);
        wr(BASE - 16'd4, 32'hEE << 2);
        rd_check("R1 below base", BASE - 16'd4, 32'h0);
        rd_check("R1 last slot unchanged", a_of(NS - 1, 0), model[NS - 1] << 2);
        rd_check("R1 first ram slot unchanged", a_of(14, 0), model[14] << 2);
    endtask

    task automatic t_rdw;
        @(negedge clk);
        bus_addr = a_of(18, 0); bus_wdata = 32'h99 << 2; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
        check("R8 old data during write", bus_rdata, model[18] << 2);
        model[18] = 32'h99;
        @(negedge clk);
        check("R8 new data after", bus_rdata, 32'h99 << 2);
    endtask

    task automatic t_batt;
        @(negedge clk); img_valid = 1;
        @(negedge clk); img_valid = 0;
        check("R7 valid clears", {31'h0, batt_low}, 32'h0);
        @(negedge clk); img_gone = 1;
        @(negedge clk); img_gone = 0;
        check("R7 gone sets", {31'h0, batt_low}, 32'h1);
        @(negedge clk); img_valid = 1;
        @(negedge clk); img_valid = 0;
        @(negedge clk); img_valid = 1; img_gone = 1;
        @(negedge clk); img_valid = 0; img_gone = 0;
        check("R7 gone wins", {31'h0, batt_low}, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < NS; i++) model[i] = '0;
        for (int i = 0; i < 14; i++) tmodel[i] = '0;
        rst = 1; bus_addr = '0; bus_wdata = '0; bus_we = 0;
        img_valid = 0; img_gone = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_merge;
        t_shift;
        t_clock;
        t_window;
        t_rdw;
        t_batt;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule